// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Generator

This block derives one output clock from four free-running source clocks. A single control word selects the source, optionally divides it by an even ratio, and starts or stops the output. Stopping is always done while the output is low, so the output never carries a shortened high pulse, and the run bit in the control word keeps reading as set until the output has really stopped.

A sleep input, asserted while the peripheral bus clocks are halted, also stops the output under the same low-phase rule. The stored run bit is left untouched, so the output comes back by itself when sleep is released. The source and the ratio may only be changed while the output is stopped. The required order is: clear the run bit, poll until it reads zero, write the new setting, then set the run bit again.

Top module: `gclk_gen`

## Requirements
- R1: After reset the control word reads all zeros and the output clock stays low.
- R2: The control word holds run at bit 0, divide-on at bit 1, source select at bits 3:2 and the ratio factor F at bits 15:8. A write stores these fields, and bits 7:4 always read zero.
- R3: With run set and divide-on clear, the output period and high time equal those of the selected source (source 0 to 3).
- R4: With divide-on set, the output period is 2×(F+1) source periods and the high time is F+1 source periods.
- R5: No output high pulse and no output low gap is shorter than the nominal high time across start and stop. After a stop the output stays low.
- R6: After run is written to zero, bit 0 still reads one on the next read and returns to zero only once the output has stopped.
- R7: While sleep is high the output stops without a runt pulse, and bit 0 keeps reading one.
- R8: When sleep falls with run still set, the output resumes on its own with its programmed period.
- R9: Setting run starts the output, and its first high pulse already has full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-side clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to store |
| rd_data | output | 16 | Control word readback with true run state |
| sleep | input | 1 | High while the peripheral bus clocks are halted |
| src_clk | input | 4 | Source clocks |
| gclk_out | output | 1 | Generated clock |

## Verification
A write becomes visible on rd_data one clk edge after the write strobe. The bench samples it at the following falling clk edge, which is also where it makes the R6 check that the run bit is still set. The output starts or stops only after the request has passed one register-side flop, two source-domain flops and a falling source edge taken while the pre-gate clock is low. For that reason the bench never expects the output at a fixed cycle count: it measures periods, pulse widths and the absence of edges in windows that begin once the readback has settled. The readback of a stop takes two more clk flops, so the run bit is polled with a bound of 400 clk cycles.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
package gclk_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SEL_W    = $clog2(NUM_SRC);
    localparam int DIV_W    = 8;
    localparam int REG_W    = 16;
    localparam int SYNC_LEN = 2;

    localparam int RUN_BIT   = 0;
    localparam int DIVON_BIT = 1;
    localparam int SRC_LSB   = 2;
    localparam int FAC_LSB   = 8;
    localparam int RSV_LSB   = SRC_LSB + SEL_W;
    localparam int RSV_W     = FAC_LSB - RSV_LSB;

    typedef struct packed {
        logic [DIV_W-1:0] factor;
        logic [SEL_W-1:0] src;
        logic             div_on;
        logic             run;
    } gclk_cfg_t;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_e;

    function automatic gclk_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        gclk_cfg_t c;
        c.run    = w[RUN_BIT];
        c.div_on = w[DIVON_BIT];
        c.src    = w[SRC_LSB +: SEL_W];
        c.factor = w[FAC_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input gclk_cfg_t c, input logic run_seen);
        logic [REG_W-1:0] w;
        w                     = '0;
        w[RUN_BIT]            = run_seen;
        w[DIVON_BIT]          = c.div_on;
        w[SRC_LSB +: SEL_W]   = c.src;
        w[RSV_LSB +: RSV_W]   = '0;
        w[FAC_LSB +: DIV_W]   = c.factor;
        return w;
    endfunction

endpackage

// File: rtl/gclk_sync.sv
`timescale 1ns/1ps
module gclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gclk_regs.sv
`timescale 1ns/1ps
module gclk_regs
    import gclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sleep,
    input  logic             running_sync,
    output gclk_cfg_t        cfg,
    output logic             req,
    output logic [REG_W-1:0] rd_data
);
    gclk_cfg_t cfg_q;
    logic      req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            req_q <= 1'b0;
        end else begin
            if (wr_en) cfg_q <= unpack_cfg(wr_data);
            req_q <= cfg_q.run & ~sleep;
        end
    end

    assign cfg     = cfg_q;
    assign req     = req_q;
    assign rd_data = pack_cfg(cfg_q, cfg_q.run | running_sync);

    a_r2_write_stores: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cfg_q == unpack_cfg($past(wr_data)));

    a_r6_run_reads_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[RUN_BIT] && running_sync) |=> rd_data[RUN_BIT]);
endmodule

// File: rtl/gclk_src_mux.sv
`timescale 1ns/1ps
module gclk_src_mux
    import gclk_pkg::*;
#(
    parameter int N = NUM_SRC,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  src_clk,
    input  logic [SW-1:0] sel,
    output logic          sel_clk
);
    logic [N-1:0] pick;

    for (genvar g = 0; g < N; g++) begin : g_pick
        assign pick[g] = src_clk[g] & (sel == SW'(g));
    end

    assign sel_clk = |pick;
endmodule

// File: rtl/gclk_divider.sv
`timescale 1ns/1ps
module gclk_divider
    import gclk_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         src_clk,
    input  logic         rst,
    input  logic         div_on,
    input  logic [W-1:0] factor,
    output logic         pre_clk,
    output logic         pre_low
);
    logic [W-1:0] cnt;
    logic         div_q;

    always_ff @(posedge src_clk) begin
        if (rst || !div_on) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (cnt >= factor) begin
            cnt   <= '0;
            div_q <= ~div_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pre_clk = div_on ? div_q : src_clk;
    assign pre_low = div_on ? ~div_q : 1'b1;

    a_r4_count_bounded: assert property (@(posedge src_clk) disable iff (rst)
        (div_on && $stable(factor)) |-> cnt <= factor);
endmodule

// File: rtl/gclk_gate.sv
`timescale 1ns/1ps
module gclk_gate
    import gclk_pkg::*;
(
    input  logic src_clk,
    input  logic rst,
    input  logic req,
    input  logic pre_clk,
    input  logic pre_low,
    output logic gclk,
    output logic gate_on
);
    logic  req_sync;
    gate_e gate_q;

    gclk_sync #(.STAGES(SYNC_LEN)) u_req_sync (
        .clk (src_clk),
        .rst (rst),
        .d   (req),
        .q   (req_sync)
    );

    always_ff @(negedge src_clk) begin
        if (rst)          gate_q <= GATE_OFF;
        else if (pre_low) gate_q <= req_sync ? GATE_ON : GATE_OFF;
    end

    assign gate_on = (gate_q == GATE_ON);
    assign gclk    = pre_clk & gate_on;

    a_r5_gate_moves_low: assert property (@(negedge src_clk) disable iff (rst)
        (gate_q != $past(gate_q)) |-> $past(pre_low));

    a_r9_gate_follows_req: assert property (@(negedge src_clk) disable iff (rst)
        pre_low |=> (gate_q == GATE_ON) == $past(req_sync));
endmodule

// File: rtl/gclk_gen.sv
`timescale 1ns/1ps
module gclk_gen
    import gclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               sleep,
    input  logic [NUM_SRC-1:0] src_clk,
    output logic               gclk_out
);
    gclk_cfg_t cfg;
    logic      req;
    logic      running_sync;
    logic      sel_clk;
    logic      pre_clk;
    logic      pre_low;
    logic      gate_on;

    gclk_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .sleep        (sleep),
        .running_sync (running_sync),
        .cfg          (cfg),
        .req          (req),
        .rd_data      (rd_data)
    );

    gclk_src_mux #(.N(NUM_SRC)) u_mux (
        .src_clk (src_clk),
        .sel     (cfg.src),
        .sel_clk (sel_clk)
    );

    gclk_divider #(.W(DIV_W)) u_div (
        .src_clk (sel_clk),
        .rst     (rst),
        .div_on  (cfg.div_on),
        .factor  (cfg.factor),
        .pre_clk (pre_clk),
        .pre_low (pre_low)
    );

    gclk_gate u_gate (
        .src_clk (sel_clk),
        .rst     (rst),
        .req     (req),
        .pre_clk (pre_clk),
        .pre_low (pre_low),
        .gclk    (gclk_out),
        .gate_on (gate_on)
    );

    gclk_sync #(.STAGES(SYNC_LEN)) u_back_sync (
        .clk (clk),
        .rst (rst),
        .d   (gate_on),
        .q   (running_sync)
    );
endmodule

// File: tb/gclk_gen_bench.sv
`timescale 1ns/1ps
module gclk_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        sleep = 1'b0;
    logic        s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic [3:0]  src_clk;
    logic        gclk_out;

    int checks = 0;
    int errors = 0;

    real rise_t = 0.0, fall_t = 0.0, min_high = 1.0e9, min_low = 1.0e9;
    int  rises = 0;

    assign src_clk = {s3, s2, s1, s0};

    always #4  clk = ~clk;
    always #5  s0 = ~s0;
    always #7  s1 = ~s1;
    always #11 s2 = ~s2;
    always #15 s3 = ~s3;

    gclk_gen u_gclk_gen (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .sleep    (sleep),
        .src_clk  (src_clk),
        .gclk_out (gclk_out)
    );

    always @(posedge gclk_out) begin
        rises = rises + 1;
        if ($realtime - fall_t < min_low) min_low = $realtime - fall_t;
        rise_t = $realtime;
    end

    always @(negedge gclk_out) begin
        if ($realtime - rise_t < min_high) min_high = $realtime - rise_t;
        fall_t = $realtime;
    end

    function automatic real src_period(input int s);
        case (s)
            0: return 10.0;
            1: return 14.0;
            2: return 22.0;
            default: return 30.0;
        endcase
    endfunction

    function automatic logic [15:0] word(input bit run, input bit don, input int s, input int f);
        return {8'(f), 4'b0000, 2'(s), don, run};
    endfunction

    function automatic bit near(input real a, input real b);
        return (a - b < 0.05) && (b - a < 0.05);
    endfunction

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_rises(input int ncyc, output int n);
        int start;
        start = rises;
        repeat (ncyc) @(negedge clk);
        n = rises - start;
    endtask

    task automatic measure(input string tag, input real exp_p, input real exp_h);
        real t0, t1, t2;
        @(posedge gclk_out);
        @(posedge gclk_out);
        t0 = $realtime;
        @(negedge gclk_out);
        t1 = $realtime;
        @(posedge gclk_out);
        t2 = $realtime;
        chk(near(t2 - t0, exp_p), $sformatf("%s period actual %0.2f expected %0.2f", tag, t2 - t0, exp_p));
        chk(near(t1 - t0, exp_h), $sformatf("%s high actual %0.2f expected %0.2f", tag, t1 - t0, exp_h));
    endtask

    task automatic stop_and_check(input string tag, input real exp_h, input int quiet_cyc);
        int n;
        wr(rd_data & 16'hFFFE);
        chk(rd_data[0] == 1'b1, $sformatf("R6 %s run bit after clear actual %0d expected 1", tag, rd_data[0]));
        for (int i = 0; i < 400 && rd_data[0]; i++) @(negedge clk);
        chk(rd_data[0] == 1'b0, $sformatf("R6 %s run bit after stop actual %0d expected 0", tag, rd_data[0]));
        chk(gclk_out == 1'b0, $sformatf("R5 %s output level after stop actual %0d expected 0", tag, gclk_out));
        count_rises(quiet_cyc, n);
        chk(n == 0, $sformatf("R5 %s rises after stop actual %0d expected 0", tag, n));
        chk(min_high >= exp_h - 0.05, $sformatf("R5 R9 %s shortest high actual %0.2f expected >= %0.2f", tag, min_high, exp_h));
        chk(min_low >= exp_h - 0.05, $sformatf("R5 %s shortest low actual %0.2f expected >= %0.2f", tag, min_low, exp_h));
    endtask

    task automatic run_cfg(input int s, input bit don, input int f);
        real p, h;
        string tag;
        p   = don ? src_period(s) * 2.0 * real'(f + 1) : src_period(s);
        h   = p / 2.0;
        tag = $sformatf("src=%0d div_on=%0d F=%0d", s, don, f);
        wr(word(1'b0, don, s, f));
        min_high = 1.0e9;
        min_low  = 1.0e9;
        wr(word(1'b1, don, s, f));
        chk(rd_data == word(1'b1, don, s, f), $sformatf("R2 %s readback actual %h expected %h", tag, rd_data, word(1'b1, don, s, f)));
        measure(don ? {"R4 ", tag} : {"R3 ", tag}, p, h);
        stop_and_check(tag, h, int'(3.0 * p / 8.0) + 4);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        real p;
        repeat (12) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 16'h0000, $sformatf("R1 reset readback actual %h expected 0000", rd_data));
        count_rises(50, n);
        chk(n == 0, $sformatf("R1 rises after reset actual %0d expected 0", n));
        chk(gclk_out == 1'b0, $sformatf("R1 output level actual %0d expected 0", gclk_out));

        // R2 field placement, reserved bits dropped, run clear keeps output off
        wr(16'hA5FE);
        chk(rd_data == 16'hA50E, $sformatf("R2 stored word actual %h expected a50e", rd_data));
        count_rises(60, n);
        chk(n == 0, $sformatf("R2 rises with run clear actual %0d expected 0", n));

        // R3 undivided on every source, R4 divided over a factor sweep
        for (int s = 0; s < 4; s++) begin
            run_cfg(s, 1'b0, 0);
            run_cfg(s, 1'b1, 0);
            run_cfg(s, 1'b1, 1);
            run_cfg(s, 1'b1, 3);
            run_cfg(s, 1'b1, 6);
        end

        // R7 sleep stop and R8 wake resume
        p = 14.0 * 2.0 * 3.0;
        wr(word(1'b0, 1'b1, 1, 2));
        min_high = 1.0e9;
        min_low  = 1.0e9;
        wr(word(1'b1, 1'b1, 1, 2));
        measure("R8 before sleep", p, p / 2.0);
        @(negedge clk);
        sleep = 1'b1;
        repeat (100) @(negedge clk);
        chk(rd_data[0] == 1'b1, $sformatf("R7 run bit in sleep actual %0d expected 1", rd_data[0]));
        chk(gclk_out == 1'b0, $sformatf("R7 output level in sleep actual %0d expected 0", gclk_out));
        count_rises(60, n);
        chk(n == 0, $sformatf("R7 rises in sleep actual %0d expected 0", n));
        chk(min_high >= p / 2.0 - 0.05, $sformatf("R7 shortest high actual %0.2f expected >= %0.2f", min_high, p / 2.0));
        sleep = 1'b0;
        measure("R8 after wake", p, p / 2.0);
        chk(min_high >= p / 2.0 - 0.05, $sformatf("R8 shortest high actual %0.2f expected >= %0.2f", min_high, p / 2.0));
        stop_and_check("after wake", p / 2.0, 30);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule